// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control unit of a small processor with no pipeline. It reads 32-bit instruction words from an instruction memory that has a one-cycle read latency. A state machine walks each instruction through four cycles: fetch, execute, wait and next. Instructions that move data between the register file, the data memory and the two external buses are carried out by the sequencer itself. Arithmetic and logic instructions go to an outside execute datapath, which receives a one-cycle strobe together with the instruction word.

Conditional jumps test one of four status flags that the datapath supplies. Each flag can be tested as set or as clear, and there is also an unconditional jump. A halt instruction freezes the program counter and every output until reset.

Instruction fields are laid out as follows:

| Field | Bits |
|---|---|
| Opcode | [31:27] |
| Destination register | [26:22] |
| Source register | [21:17] |
| Data address or jump target | [15:0] |

Bit 16 is a mode bit that the sequencer passes through to the datapath untouched. Flag bit positions are: carry [0], zero [1], sign [2], overflow [3].

Top module: `seq_ctrl`

## Requirements
- R1: While reset is high, `imem_addr` is 0 and `ext_out` is 0, and `halted`, `dmem_we`, `rf_we` and `exe_go` are all low. The first cycle after reset is released is a fetch cycle.
- R2: Every instruction other than halt takes exactly four cycles. The program counter changes only at the end of the last of those four cycles.
- R3: `imem_addr` carries the program counter. The word that the memory returns one cycle after the fetch cycle is the instruction that gets executed.
- R4: Opcodes 0 to 11 are sent to the datapath. `exe_go` is high for exactly one cycle, the third cycle of the instruction, and during that cycle `exe_word` equals the instruction word.
- R5: Opcode 12 (store register) asserts `dmem_we` for exactly one cycle, the fourth cycle of the instruction. `dmem_addr` is the low address bits of the instruction, and `dmem_wdata` is the register selected by the source field.
- R6: Opcode 13 (store input) writes the value that `ext_in` holds during the third cycle into data memory, at the instruction's address, in the fourth cycle.
- R7: Opcode 14 (send output) loads `ext_out` with the data-memory word at the instruction's address at the end of the fourth cycle. At every other time `ext_out` keeps its value.
- R8: Opcode 15 (load) asserts `rf_we` for exactly one cycle, the fetch cycle of the following instruction. `rf_waddr` is the destination field and `rf_wdata` is the data-memory word at the instruction's address.
- R9: Opcode 16 always jumps. Opcodes 17 to 24 jump on carry set, carry clear, zero set, zero clear, sign set, sign clear, overflow set and overflow clear, in that order. The flags are sampled in the second cycle. A jump that is taken loads the low PC bits of the target field. Otherwise the program counter increments by one and wraps at the top of the address range.
- R10: Opcode 31 (halt) raises `halted` after its second cycle. After that no further fetch takes place, and `imem_addr`, `ext_out` and all strobes hold until reset.
- R11: Opcodes 25 to 30 do nothing. They raise no strobe and advance the program counter by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W | Instruction memory read address (the program counter) |
| imem_rdata | input | 32 | Instruction word, one cycle after the address |
| dmem_addr | output | DA_W | Data memory address |
| dmem_we | output | 1 | Data memory write enable |
| dmem_wdata | output | DW | Data memory write data |
| dmem_rdata | input | DW | Data memory read data, one cycle after the address |
| ext_in | input | DW | External input bus |
| ext_out | output | DW | Registered external output bus |
| flags | input | 4 | Status flags: carry, zero, sign, overflow (bits 0 to 3) |
| rf_raddr | output | RA_W | Register file read address |
| rf_rdata | input | DW | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | RA_W | Register file write address |
| rf_wdata | output | DW | Register file write data |
| exe_go | output | 1 | One-cycle strobe to the execute datapath |
| exe_word | output | 32 | Instruction word for the datapath |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
Some properties are checked by assertions on every cycle. These are the single-cycle width of the datapath, memory-write and register-write strobes, the rule that the program counter and `ext_out` move only at the end of an instruction's last cycle, the increment on a jump that is not taken, and the frozen state after halt. Other behaviour can only be shown by the bench's scenarios, which run against a reference interpreter:
- which data lands at which address;
- whether each of the eight flag tests takes the correct branch;
- the wrap of the program counter;
- that the load result reaches the register file on the next fetch;
- that the sequencer recovers when reset follows a halt.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int OPC_W   = 5;
  localparam int OPC_LSB = 27;
  localparam int RD_LSB  = 22;
  localparam int RS_LSB  = 17;

  localparam logic [OPC_W-1:0] OP_ALU_LAST = 5'd11;
  localparam logic [OPC_W-1:0] OP_STREG    = 5'd12;
  localparam logic [OPC_W-1:0] OP_STIN     = 5'd13;
  localparam logic [OPC_W-1:0] OP_SEND     = 5'd14;
  localparam logic [OPC_W-1:0] OP_LOAD     = 5'd15;
  localparam logic [OPC_W-1:0] OP_JMP      = 5'd16;
  localparam logic [OPC_W-1:0] OP_JC_FIRST = 5'd17;
  localparam logic [OPC_W-1:0] OP_JC_LAST  = 5'd24;
  localparam logic [OPC_W-1:0] OP_HALT     = 5'd31;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_EXEC, ST_WAIT, ST_NEXT, ST_HALT
  } seq_state_t;

  typedef enum logic [2:0] {
    K_ALU, K_STREG, K_STIN, K_SEND, K_LOAD, K_JUMP, K_HALT, K_NOP
  } op_kind_t;

  typedef struct packed {
    op_kind_t   kind;
    logic       uncond;
    logic [2:0] test;
  } dec_t;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output dec_t             dec
);
  logic [OPC_W-1:0] rel;

  always_comb begin
    rel        = opc - OP_JC_FIRST;
    dec.kind   = K_NOP;
    dec.uncond = 1'b0;
    dec.test   = rel[2:0];
    if (opc <= OP_ALU_LAST) begin
      dec.kind = K_ALU;
    end else if (opc == OP_STREG) begin
      dec.kind = K_STREG;
    end else if (opc == OP_STIN) begin
      dec.kind = K_STIN;
    end else if (opc == OP_SEND) begin
      dec.kind = K_SEND;
    end else if (opc == OP_LOAD) begin
      dec.kind = K_LOAD;
    end else if (opc == OP_JMP) begin
      dec.kind   = K_JUMP;
      dec.uncond = 1'b1;
    end else if (opc >= OP_JC_FIRST && opc <= OP_JC_LAST) begin
      dec.kind = K_JUMP;
    end else if (opc == OP_HALT) begin
      dec.kind = K_HALT;
    end
  end
endmodule

// File: rtl/seq_cond.sv
module seq_cond
  import seq_pkg::*;
#(
  parameter int NFLAG = 4
) (
  input  dec_t             dec,
  input  logic [NFLAG-1:0] flags,
  output logic             take
);
  localparam int NTEST = 2 * NFLAG;
  localparam int SEL_W = $clog2(NTEST);

  logic [NTEST-1:0] hit;
  logic [SEL_W-1:0] sel;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign hit[2*i]   = flags[i];
    assign hit[2*i+1] = ~flags[i];
  end

  assign sel  = dec.test[SEL_W-1:0];
  assign take = (dec.kind == K_JUMP) && (dec.uncond || hit[sel]);
endmodule

// File: rtl/seq_pc.sv
module seq_pc #(
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic            take,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
    end else if (step) begin
      pc <= take ? target : pc + 1'b1;
    end
  end

  // R9
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !take) |=> pc == PC_W'($past(pc) + 1'b1));

  // R9
  pc_load_chk: assert property (@(posedge clk) disable iff (rst)
    (step && take) |=> pc == $past(target));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int PC_W = 8,
  parameter int DA_W = 8,
  parameter int DW   = 16,
  parameter int RA_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PC_W-1:0] imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic [DA_W-1:0] dmem_addr,
  output logic            dmem_we,
  output logic [DW-1:0]   dmem_wdata,
  input  logic [DW-1:0]   dmem_rdata,
  input  logic [DW-1:0]   ext_in,
  output logic [DW-1:0]   ext_out,
  input  logic [3:0]      flags,
  output logic [RA_W-1:0] rf_raddr,
  input  logic [DW-1:0]   rf_rdata,
  output logic            rf_we,
  output logic [RA_W-1:0] rf_waddr,
  output logic [DW-1:0]   rf_wdata,
  output logic            exe_go,
  output logic [31:0]     exe_word,
  output logic            halted
);
  seq_state_t      st;
  dec_t            dec;
  op_kind_t        kind_q;
  logic            take, take_q;
  logic [31:0]     ir;
  logic [PC_W-1:0] pc;

  seq_decode u_dec (
    .opc (imem_rdata[OPC_LSB +: OPC_W]),
    .dec (dec)
  );

  seq_cond #(.NFLAG(4)) u_cond (
    .dec   (dec),
    .flags (flags),
    .take  (take)
  );

  seq_pc #(.PC_W(PC_W)) u_pc (
    .clk    (clk),
    .rst    (rst),
    .step   (st == ST_NEXT),
    .take   (take_q),
    .target (ir[PC_W-1:0]),
    .pc     (pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      ir         <= '0;
      kind_q     <= K_NOP;
      take_q     <= 1'b0;
      dmem_addr  <= '0;
      dmem_we    <= 1'b0;
      dmem_wdata <= '0;
      ext_out    <= '0;
      rf_raddr   <= '0;
      rf_we      <= 1'b0;
      rf_waddr   <= '0;
      rf_wdata   <= '0;
      exe_go     <= 1'b0;
      halted     <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: st <= ST_FETCH;
        ST_FETCH: begin
          rf_we <= 1'b0;
          st    <= ST_EXEC;
        end
        ST_EXEC: begin
          ir        <= imem_rdata;
          kind_q    <= dec.kind;
          take_q    <= take;
          dmem_addr <= imem_rdata[DA_W-1:0];
          rf_raddr  <= imem_rdata[RS_LSB +: RA_W];
          if (dec.kind == K_HALT) begin
            halted <= 1'b1;
            st     <= ST_HALT;
          end else begin
            exe_go <= (dec.kind == K_ALU);
            st     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          exe_go <= 1'b0;
          if (kind_q == K_STREG) begin
            dmem_we    <= 1'b1;
            dmem_wdata <= rf_rdata;
          end else if (kind_q == K_STIN) begin
            dmem_we    <= 1'b1;
            dmem_wdata <= ext_in;
          end
          st <= ST_NEXT;
        end
        ST_NEXT: begin
          dmem_we <= 1'b0;
          if (kind_q == K_SEND) begin
            ext_out <= dmem_rdata;
          end
          if (kind_q == K_LOAD) begin
            rf_we    <= 1'b1;
            rf_waddr <= ir[RD_LSB +: RA_W];
            rf_wdata <= dmem_rdata;
          end
          st <= ST_FETCH;
        end
        default: st <= ST_HALT;
      endcase
    end
  end

  assign imem_addr = pc;
  assign exe_word  = ir;

  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st != ST_NEXT) |=> $stable(imem_addr));

  // R4
  exe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    exe_go |=> !exe_go);

  // R5
  dmem_we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |=> !dmem_we);

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st != ST_NEXT) |=> $stable(ext_out));

  // R8
  rf_we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> !rf_we);

  // R10
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(imem_addr) && $stable(ext_out)
                && !dmem_we && !rf_we && !exe_go));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({exe_go, dmem_we, rf_we}));
endmodule

// File: tb/seq_ctrl_bench.sv
module seq_ctrl_bench;
  localparam int PC_W = 8;
  localparam int DA_W = 8;
  localparam int DW   = 16;
  localparam int RA_W = 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PC_W-1:0] imem_addr;
  logic [31:0]     imem_q;
  logic [DA_W-1:0] dmem_addr;
  logic            dmem_we;
  logic [DW-1:0]   dmem_wdata, dmem_q;
  logic [DW-1:0]   ext_in = '0;
  logic [DW-1:0]   ext_out;
  logic [3:0]      flags = '0;
  logic [RA_W-1:0] rf_raddr, rf_waddr;
  logic [DW-1:0]   rf_rdata, rf_wdata;
  logic            rf_we, exe_go, halted;
  logic [31:0]     exe_word;

  logic [31:0] imem [2**PC_W];
  logic [DW-1:0] dmem [2**DA_W];
  logic [DW-1:0] rf [2**RA_W];
  logic [DW-1:0] e_dmem [2**DA_W];
  logic [DW-1:0] e_rf [2**RA_W];

  logic [PC_W-1:0] e_pc;
  logic [DW-1:0]   e_out;
  bit              pend_ld;
  logic [RA_W-1:0] pend_rd;
  logic [DW-1:0]   pend_val;
  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  seq_ctrl #(.PC_W(PC_W), .DA_W(DA_W), .DW(DW), .RA_W(RA_W)) u_seq_ctrl (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_q),
    .dmem_addr(dmem_addr), .dmem_we(dmem_we), .dmem_wdata(dmem_wdata),
    .dmem_rdata(dmem_q), .ext_in(ext_in), .ext_out(ext_out), .flags(flags),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .exe_go(exe_go),
    .exe_word(exe_word), .halted(halted)
  );

  always @(posedge clk) begin
    imem_q <= imem[imem_addr];
    dmem_q <= dmem[dmem_addr];
    if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
    if (rf_we) rf[rf_waddr] <= rf_wdata;
  end
  assign rf_rdata = rf[rf_raddr];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_err++;
      $display("FAIL R2 watchdog expired: actual %0d cycles expected below 100000", cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  function automatic bit jtake(input logic [4:0] op, input logic [3:0] f);
    case (op)
      5'd16: return 1'b1;
      5'd17: return f[0];
      5'd18: return !f[0];
      5'd19: return f[1];
      5'd20: return !f[1];
      5'd21: return f[2];
      5'd22: return !f[2];
      5'd23: return f[3];
      5'd24: return !f[3];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] mk(input int op, input int rd, input int rs, input int a);
    logic [31:0] w;
    w = $urandom;
    w[31:27] = op[4:0];
    w[26:22] = rd[4:0];
    w[21:17] = rs[4:0];
    w[15:0]  = a[15:0];
    return w;
  endfunction

  task automatic fill_random();
    for (int i = 0; i < 2**PC_W; i++) imem[i] = mk($urandom_range(0, 30), $urandom, $urandom, $urandom);
  endtask

  task automatic do_reset();
    @(negedge clk);
    if (pend_ld) e_rf[pend_rd] = pend_val;
    pend_ld = 0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(imem_addr == '0, "R1 reset pc", imem_addr, 0);
    chk(ext_out == '0, "R1 reset ext_out", ext_out, 0);
    chk({halted, dmem_we, rf_we, exe_go} == 4'b0, "R1 reset strobes",
        {halted, dmem_we, rf_we, exe_go}, 0);
    e_pc = '0;
    e_out = '0;
    rst = 1'b0;
  endtask

  task automatic step();
    logic [31:0] w;
    logic [4:0] op;
    logic [DA_W-1:0] a;
    logic [3:0] f;
    logic [DW-1:0] sd;
    bit isst;
    @(negedge clk);
    chk(imem_addr == e_pc, "R3 R9 fetch address", imem_addr, e_pc);
    chk(ext_out == e_out, "R7 ext_out value", ext_out, e_out);
    if (pend_ld) begin
      chk(rf_we && rf_waddr == pend_rd && rf_wdata == pend_val, "R8 register write",
          {rf_we, rf_waddr, rf_wdata}, {1'b1, pend_rd, pend_val});
      e_rf[pend_rd] = pend_val;
      pend_ld = 0;
    end else begin
      chk(!rf_we, "R8 no register write", rf_we, 0);
    end
    ext_in = DW'($urandom);
    w = imem[e_pc];
    op = w[31:27];
    a = w[DA_W-1:0];
    f = flags;
    @(negedge clk);
    if (op == 5'd31) begin
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        chk(halted && imem_addr == e_pc && ext_out == e_out, "R10 frozen after halt",
            {halted, imem_addr, ext_out}, {1'b1, e_pc, e_out});
        chk({dmem_we, rf_we, exe_go} == 3'b0, "R10 no strobes after halt",
            {dmem_we, rf_we, exe_go}, 0);
      end
      return;
    end
    chk(!halted, "R10 halted low while running", halted, 0);
    @(negedge clk);
    chk(exe_go == (op <= 5'd11), (op >= 5'd25) ? "R11 no strobe" : "R4 datapath strobe",
        exe_go, op <= 5'd11);
    if (op <= 5'd11) begin
      chk(exe_word == w, "R4 instruction word", exe_word, w);
      flags = 4'($urandom);
    end
    if (op >= 5'd12 && op <= 5'd15) chk(dmem_addr == a, "R5 data address", dmem_addr, a);
    @(negedge clk);
    isst = (op == 5'd12) || (op == 5'd13);
    sd = (op == 5'd12) ? e_rf[w[21:17]] : ext_in;
    chk(dmem_we == isst, (op == 5'd13) ? "R6 write enable" : "R5 write enable", dmem_we, isst);
    if (isst) begin
      chk(dmem_wdata == sd, (op == 5'd13) ? "R6 input data" : "R5 register data", dmem_wdata, sd);
      e_dmem[a] = sd;
    end
    if (op == 5'd14) e_out = e_dmem[a];
    if (op == 5'd15) begin
      pend_ld = 1;
      pend_rd = w[26:22];
      pend_val = e_dmem[a];
    end
    e_pc = jtake(op, f) ? w[PC_W-1:0] : e_pc + 1'b1;
  endtask

  initial begin
    void'($urandom(32'h5EC0_1234));
    for (int i = 0; i < 2**DA_W; i++) begin
      dmem[i] = DW'($urandom);
      e_dmem[i] = dmem[i];
    end
    for (int i = 0; i < 2**RA_W; i++) begin
      rf[i] = DW'($urandom);
      e_rf[i] = rf[i];
    end
    pend_ld = 0;
    e_pc = '0;
    e_out = '0;

    // Directed: store input, send, load, store register, jump to the top and wrap (R6 R7 R8 R5 R9)
    fill_random();
    imem[0] = mk(13, 0, 0, 5);
    imem[1] = mk(14, 0, 0, 5);
    imem[2] = mk(15, 3, 0, 5);
    imem[3] = mk(12, 0, 3, 9);
    imem[4] = mk(14, 0, 0, 9);
    imem[5] = mk(2, 1, 2, 0);
    imem[6] = mk(16, 0, 0, 16'hFFFF);
    imem[255] = mk(27, 0, 0, 0);
    do_reset();
    for (int i = 0; i < 10; i++) step();

    // Random program (R2 R3 R4 R5 R6 R7 R8 R9 R11)
    fill_random();
    do_reset();
    for (int i = 0; i < 400; i++) step();

    // Halt, then recovery through reset (R10)
    imem[0] = mk(3, 0, 0, 0);
    imem[1] = mk(13, 0, 0, 7);
    imem[2] = mk(14, 0, 0, 7);
    imem[3] = mk(31, 0, 0, 0);
    do_reset();
    for (int i = 0; i < 4; i++) step();
    do_reset();
    step();

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule